// File: doc/BRIEF.md
# Serial register bank with burst access

This block is a serial-peripheral slave that gives an external host read and write access to 2^ADDR_W registers of DATA_W bits. With the defaults there are 128 registers of eight bits. The host pulls the active-low select low and then shifts in a command frame on the serial data input. The frame is one direction bit followed by the register address, most significant bit first. Data bytes follow the frame.

In a write, each completed data byte is committed to the addressed register. In a read, the addressed register is shifted out on the serial data output. Either way, the address then advances by one, with wrap-around, for as long as select stays low. A host can therefore stream through consecutive registers after sending a single address.

The serial pins are brought into the system clock domain through synchronizer chains. The system clock must run at least four times faster than the serial clock. Input data is taken on the rising serial-clock edge and output data changes on the falling edge. The register array is held inside the block. Its parallel port (address, write data, write strobe, read data) is also brought out so that register traffic can be observed.

Top module: `spi_burst_regbank`

## Requirements
- R1: The first bit sampled after select falls chooses the direction: 1 makes the transaction a write, 0 makes it a read.
- R2: The ADDR_W address bits follow the direction bit, most significant first, and they select the first register accessed.
- R3: Write data arrives most significant bit first, and the completed byte appears on `reg_wdata` with a one-cycle `reg_we` pulse.
- R4: A single write of 1+ADDR_W+DATA_W serial clocks (16 with the defaults) changes exactly one register, the addressed one.
- R5: In a burst write, every further DATA_W serial clocks commit one more byte, to the next higher address. `reg_we` is only raised in the cycle that takes in a rising serial-clock edge.
- R6: In a read, `sdo` presents the addressed register most significant bit first during the DATA_W clocks after the address. `sdo` changes only after a falling serial-clock edge, so the value on `sdo` is valid at each rising edge.
- R7: In a burst read, the next register's byte follows on `sdo` with no gap between bytes.
- R8: Auto-increment wraps from the highest address (0x7F with the defaults) to 0x00.
- R9: Raising select discards a partly received byte without any write. The next transaction starts again with a direction bit.
- R10: `sdo` is 0 whenever select is high.
- R11: A read never writes a register, whatever is driven on the serial data input during its data bytes.
- R12: After reset, every register reads 0, `sdo` is 0 and `reg_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host (idles low) |
| sdi | input | 1 | Serial data from the host |
| sel_n | input | 1 | Active-low select |
| sdo | output | 1 | Serial data to the host |
| reg_addr | output | ADDR_W | Current register address on the parallel port |
| reg_wdata | output | DATA_W | Byte being written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | output | DATA_W | Contents of the register at `reg_addr` |

## Verification
The bench uses the defaults: seven address bits, eight data bits and a two-stage synchronizer. At these sizes a three-byte burst starting at 0x7E crosses the 0x7F-to-0x00 wrap, so the wrap can be reached in a short run. The frame is exactly one byte, so the command frame and the data bytes share the same counter limit. The serial clock runs at one eighth of the system clock. That leaves one spare system cycle between the synchronizer's output update on `sdo` and the host's sampling point.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

  // Frame position inside a selected transaction
  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_rest
        assign stage_d = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[g] <= RST_VAL;
        end else begin
          chain_q[g] <= stage_d;
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/spi_rb_engine.sv
module spi_rb_engine
  import spi_rb_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              sel_n_s,
  output logic              sclk_rise,
  output logic              sclk_fall,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              sdo
);

  localparam int FRAME_W = 1 + ADDR_W;
  localparam int SH_W    = max_int(FRAME_W, DATA_W);
  localparam int CNT_W   = $clog2(SH_W);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  // registers
  logic              sclk_q;
  phase_t            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SH_W-1:0]   shift_q, shift_d;
  logic              dir_wr_q, dir_wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              load_q, load_d;
  logic              sdo_q, sdo_d;

  // decode
  logic              active;
  logic [SH_W-1:0]   shift_in;
  logic              last_bit;
  logic              unit_done;
  logic              cmd_done;
  logic              data_done;

  assign active    = ~sel_n_s;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign shift_in  = {shift_q[SH_W-2:0], sdi_s};
  assign last_bit  = (phase_q == PH_CMD) ? (cnt_q == CMD_LAST) : (cnt_q == DATA_LAST);
  assign unit_done = active & sclk_rise & last_bit;
  assign cmd_done  = unit_done & (phase_q == PH_CMD);
  assign data_done = unit_done & (phase_q == PH_DATA);

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    shift_d  = shift_q;
    dir_wr_d = dir_wr_q;
    addr_d   = addr_q;
    tx_d     = tx_q;
    load_d   = load_q;
    sdo_d    = sdo_q;
    if (!active) begin
      phase_d = PH_CMD;
      cnt_d   = '0;
      load_d  = 1'b0;
      sdo_d   = 1'b0;
    end else if (sclk_rise) begin
      shift_d = shift_in;
      cnt_d   = last_bit ? '0 : cnt_q + 1'b1;
      if (cmd_done) begin
        dir_wr_d = shift_in[FRAME_W-1];
        addr_d   = shift_in[ADDR_W-1:0];
        phase_d  = PH_DATA;
        load_d   = ~shift_in[FRAME_W-1];
      end else if (data_done) begin
        addr_d = addr_q + 1'b1;
        load_d = ~dir_wr_q;
      end
    end else if (sclk_fall) begin
      if (load_q) begin
        sdo_d  = reg_rdata[DATA_W-1];
        tx_d   = {reg_rdata[DATA_W-2:0], 1'b0};
        load_d = 1'b0;
      end else if ((phase_q == PH_DATA) && !dir_wr_q) begin
        sdo_d = tx_q[DATA_W-1];
        tx_d  = {tx_q[DATA_W-2:0], 1'b0};
      end else begin
        sdo_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      phase_q  <= PH_CMD;
      cnt_q    <= '0;
      shift_q  <= '0;
      dir_wr_q <= 1'b0;
      addr_q   <= '0;
      tx_q     <= '0;
      load_q   <= 1'b0;
      sdo_q    <= 1'b0;
    end else begin
      sclk_q   <= sclk_s;
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      shift_q  <= shift_d;
      dir_wr_q <= dir_wr_d;
      addr_q   <= addr_d;
      tx_q     <= tx_d;
      load_q   <= load_d;
      sdo_q    <= sdo_d;
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = shift_in[DATA_W-1:0];
  assign reg_we    = data_done & dir_wr_q;
  assign sdo       = sdo_q;

endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_reg
      logic hit;
      assign hit = we && (addr == ADDR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[g] <= '0;
        end else if (hit) begin
          mem_q[g] <= wdata;
        end
      end
    end
  endgenerate

  assign rdata = mem_q[addr];

endmodule

// File: rtl/spi_burst_regbank.sv
module spi_burst_regbank #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              sel_n,
  output logic              sdo,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata
);

  logic [2:0] pins_s;
  logic       sclk_s;
  logic       sdi_s;
  logic       sel_n_s;
  logic       sclk_rise;
  logic       sclk_fall;

  spi_rb_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in({sel_n, sdi, sclk}),
    .sync_out(pins_s)
  );

  assign sel_n_s = pins_s[2];
  assign sdi_s   = pins_s[1];
  assign sclk_s  = pins_s[0];

  spi_rb_engine #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (sclk_s),
    .sdi_s    (sdi_s),
    .sel_n_s  (sel_n_s),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we),
    .reg_rdata(reg_rdata),
    .sdo      (sdo)
  );

  spi_rb_regfile #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (reg_addr),
    .wdata(reg_wdata),
    .we   (reg_we),
    .rdata(reg_rdata)
  );

endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n_s,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              sdo
);

  // R10: output parked low one cycle after deselect is seen
  assert_sdo_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s |=> (sdo == 1'b0));

  // R9: no commit outside a selected transaction
  assert_write_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !sel_n_s);

  // R5: commits coincide with a rising serial edge
  assert_write_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> sclk_rise);

  // R8: address steps by one (modulo) after each commit
  assert_addr_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == ADDR_W'($past(reg_addr) + 1)));

  // R6: serial output only moves after a falling edge
  assert_sdo_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n_s && !sclk_fall) |=> $stable(sdo));

endmodule

bind spi_burst_regbank spi_rb_checker #(
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_n_s  (sel_n_s),
  .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .sdo      (sdo)
);

// File: tb/spi_burst_regbank_tb.sv
module spi_burst_regbank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;
  localparam int AW = 7;
  localparam int DW = 8;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sclk;
  logic          sdi;
  logic          sel_n;
  logic          sdo;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic          reg_we;
  logic [DW-1:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int idle_cnt = 0;
  string cur_req = "R12";

  logic [DW-1:0] model_mem [1 << AW];
  logic [AW+DW-1:0] exp_wr [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_burst_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .sel_n(sel_n),
    .sdo(sdo), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Per-clock reference comparison of the parallel port and idle output
  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (rst_n) begin
      idle_cnt = sel_n ? idle_cnt + 1 : 0;
      if (idle_cnt >= 4) check("R10", "sdo while deselected", sdo, 0);
      if (reg_we) begin
        if (exp_wr.size() == 0) begin
          check(cur_req, "unexpected write addr", reg_addr, -1);
        end else begin
          logic [AW+DW-1:0] e;
          e = exp_wr.pop_front();
          check(cur_req, "write addr", reg_addr, e[AW+DW-1:DW]);
          check(cur_req, "write data", reg_wdata, e[DW-1:0]);
        end
      end
    end
  end

  task automatic half();
    repeat (HALF_SCLK) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [DW-1:0] tx, input int nbits,
                           output logic [DW-1:0] rx);
    rx = '0;
    for (int i = DW - 1; i >= DW - nbits; i--) begin
      sdi = tx[i];
      half();
      rx[i] = sdo;
      sclk = 1'b1;
      half();
      sclk = 1'b0;
    end
  endtask

  task automatic open_cmd(input logic wr, input logic [AW-1:0] a);
    logic [DW-1:0] dummy;
    sel_n = 1'b0;
    half();
    xfer_bits({wr, a}, DW, dummy);
  endtask

  task automatic close_txn();
    half();
    sel_n = 1'b1;
    sdi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic burst_write(input logic [AW-1:0] a, input logic [DW-1:0] d [$]);
    logic [DW-1:0] dummy;
    open_cmd(1'b1, a);
    for (int k = 0; k < d.size(); k++) begin
      logic [AW-1:0] ak;
      ak = a + AW'(k);
      exp_wr.push_back({ak, d[k]});
      model_mem[ak] = d[k];
      xfer_bits(d[k], DW, dummy);
    end
    close_txn();
  endtask

  task automatic burst_read(input string req, input logic [AW-1:0] a,
                            input int n, input logic [DW-1:0] junk);
    logic [DW-1:0] got;
    open_cmd(1'b0, a);
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] ak;
      ak = a + AW'(k);
      xfer_bits(junk, DW, got);
      check(req, $sformatf("read byte %0d at 0x%0h", k, ak), got, model_mem[ak]);
    end
    close_txn();
  endtask

  initial begin
    logic [DW-1:0] dq [$];
    logic [DW-1:0] dummy;
    for (int i = 0; i < (1 << AW); i++) model_mem[i] = '0;
    rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0; sel_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    check("R12", "sdo after reset", sdo, 0);
    check("R12", "reg_we after reset", reg_we, 0);
    burst_read("R12", 7'h00, 4, 8'h00);

    // R1 R2 R3 R4: single write, then single read back (R6)
    cur_req = "R4";
    dq = '{8'hA5};
    burst_write(7'h05, dq);
    check("R4", "writes outstanding", exp_wr.size(), 0);
    burst_read("R6", 7'h05, 1, 8'h00);
    burst_read("R4", 7'h04, 3, 8'h00);

    // R5 burst write, R7 burst read
    cur_req = "R5";
    dq = '{8'h11, 8'h82, 8'h3C, 8'hF0};
    burst_write(7'h10, dq);
    check("R5", "writes outstanding", exp_wr.size(), 0);
    burst_read("R7", 7'h10, 4, 8'h00);

    // R8 wrap-around on write and read
    cur_req = "R8";
    dq = '{8'h5A, 8'hC3, 8'h96};
    burst_write(7'h7E, dq);
    check("R8", "writes outstanding", exp_wr.size(), 0);
    burst_read("R8", 7'h7F, 2, 8'h00);

    // R9: partial byte discarded, next transaction framed afresh
    cur_req = "R9";
    open_cmd(1'b1, 7'h20);
    xfer_bits(8'hFF, 5, dummy);
    close_txn();
    check("R9", "writes after partial byte", exp_wr.size(), 0);
    burst_read("R9", 7'h20, 1, 8'h00);
    dq = '{8'h77};
    burst_write(7'h21, dq);
    check("R9", "writes outstanding", exp_wr.size(), 0);
    burst_read("R9", 7'h20, 2, 8'h00);

    // R11: read with noise on sdi writes nothing
    cur_req = "R11";
    burst_read("R11", 7'h10, 3, 8'hFF);
    burst_read("R11", 7'h10, 3, 8'h00);

    // R1: direction bit 0 selects read even with address bits set
    cur_req = "R1";
    burst_read("R1", 7'h7F, 1, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule